// File: doc/BRIEF.md
# Cycle-Counted Accumulator Instruction Executor

This block is a small 8-bit processing core. It runs a handful of instructions straight out of a byte-wide read-only program store. It keeps an accumulator, six general byte registers that pair up into three 16-bit pairs, a 16-bit stack pointer, a 16-bit program counter and four condition flags. Each instruction is fetched, decoded and given its immediate bytes. The core then sits idle until that instruction's fixed clock budget is used up, and only then fetches the next opcode.

Two kinds of instruction are supported. The first adds an immediate byte to the accumulator and updates the flags. The second loads a 16-bit immediate into one of the three register pairs or into the stack pointer. Any other opcode stops the core for good and raises a sticky error output. A debug port shows every register and flag. A one-cycle retire pulse marks the end of each instruction, so a model that runs alongside can compare state at every instruction boundary.

Top module: `tcpu_core`

## Requirements
- R1: While reset is held, the core shows A=0x11, B=0x00, C=0x00, D=0xFF, E=0x56, H=0x00, L=0x0D, SP=0xFFFE, PC=0x0000, and flags {Z,N,H,C}=4'b1000 on dbgFlags (bit 3 Z, bit 2 N, bit 1 H, bit 0 C).
- R2: Opcode 0xC6 adds the byte at PC+1 to A and keeps only the low 8 bits. PC grows by 2.
- R3: After 0xC6, Z is 1 when the 8-bit result is zero, N is 0, H is 1 when the sum of the two low nibbles exceeds 15, and C is 1 when the 9-bit sum exceeds 255.
- R4: Opcodes 0x01, 0x11, 0x21 and 0x31 load a 16-bit immediate, with the low byte at PC+1 and the high byte at PC+2. Opcode bits [5:4] select the target: 0 for B:C, 1 for D:E, 2 for H:L, 3 for SP. The high byte goes to B, D or H and the low byte to C, E or L. PC grows by 3.
- R5: From one opcode fetch to the next, 0xC6 takes exactly 8 clocks and each load takes exactly 12. retire is high for one clock, in the last of those clocks, and the registers already hold the instruction's results in that clock.
- R6: An opcode outside the five supported values sets illegalOp, which then stays at 1 until reset. After that no register or flag changes, PC stays at the address of the bad opcode, and retire stays low.
- R7: progAddr presents PC in the clock that follows each retire pulse, to fetch the next opcode. The program store returns data one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| progAddr | output | 16 | Program store read address |
| progData | input | 8 | Program store data, one clock after progAddr |
| retire | output | 1 | One-clock pulse at the end of each instruction |
| illegalOp | output | 1 | Sticky unsupported-opcode error |
| dbgA | output | 8 | Accumulator |
| dbgB | output | 8 | Register B |
| dbgC | output | 8 | Register C |
| dbgD | output | 8 | Register D |
| dbgE | output | 8 | Register E |
| dbgH | output | 8 | Register H |
| dbgL | output | 8 | Register L |
| dbgSp | output | 16 | Stack pointer |
| dbgPc | output | 16 | Program counter |
| dbgFlags | output | 4 | {Z,N,H,C} |

## Verification
The hardest case to reach from the ports is a half-carry that arrives without a full carry, or a full carry that arrives without a half-carry, together with a zero result. These need the accumulator to hold a particular value before the add, and the accumulator can only be steered through earlier adds. A directed program therefore chains adds that land on 0x00 with both carries set, then 0x00 with no carries, then exactly 15 in the low nibble, then a half-carry only, then a full carry only. Random programs follow, mixing adds and all four loads, and each one ends on an unsupported opcode so that the halt path runs after many different register states.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_OPC,
    ST_IMM1,
    ST_IMM2,
    ST_WAIT,
    ST_HALT
  } state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic [1:0] addrOff;   // progAddr = pc + addrOff
    logic       doAdd;     // execute accumulator add with progData
    logic       latchLow;  // capture low immediate byte
    logic       loadWide;  // write 16-bit immediate to a pair or SP
    logic [1:0] pairSel;   // 0 BC, 1 DE, 2 HL, 3 SP
    logic [1:0] pcStep;    // amount added to pc this cycle
  } strobe_t;

  localparam logic [7:0] OP_ADDI = 8'hC6;

  localparam logic [7:0]  RST_A  = 8'h11;
  localparam logic [15:0] RST_SP = 16'hFFFE;
  localparam logic [15:0] RST_PC = 16'h0000;
  // Packed per pair, pair 0 in the low byte: {HL, DE, BC}
  localparam logic [23:0] RST_HI = {8'h00, 8'hFF, 8'h00};
  localparam logic [23:0] RST_LO = {8'h0D, 8'h56, 8'h00};
  localparam logic [3:0]  RST_FLAGS = 4'b1000;

  function automatic logic isWideLoad(input logic [7:0] op);
    return (op[7:6] == 2'b00) && (op[3:0] == 4'h1);
  endfunction

endpackage

// File: rtl/tcpu_ctrl.sv
module tcpu_ctrl
  import tcpu_pkg::*;
#(
  parameter int ADD_CYCLES  = 8,
  parameter int LOAD_CYCLES = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] progData,
  output strobe_t    strb,
  output logic       retire,
  output logic       illegalOp
);

  localparam int CNT_W = $clog2(LOAD_CYCLES + 1);
  // Cycles already spent in FETCH/OPC/IMM states are subtracted
  localparam logic [CNT_W-1:0] ADD_WAIT  = CNT_W'(ADD_CYCLES - 3);
  localparam logic [CNT_W-1:0] LOAD_WAIT = CNT_W'(LOAD_CYCLES - 4);

  state_t state, nextState;
  logic [7:0] opcode;
  logic [CNT_W-1:0] waitCnt;
  logic illegalQ;

  always_comb begin
    strb = '0;
    nextState = state;
    unique case (state)
      ST_FETCH: begin
        strb.addrOff = 2'd0;
        nextState = ST_OPC;
      end
      ST_OPC: begin
        strb.addrOff = 2'd1;
        if (progData == OP_ADDI || isWideLoad(progData)) nextState = ST_IMM1;
        else nextState = ST_HALT;
      end
      ST_IMM1: begin
        if (opcode == OP_ADDI) begin
          strb.doAdd  = 1'b1;
          strb.pcStep = 2'd2;
          nextState   = ST_WAIT;
        end else begin
          strb.latchLow = 1'b1;
          strb.addrOff  = 2'd2;
          nextState     = ST_IMM2;
        end
      end
      ST_IMM2: begin
        strb.loadWide = 1'b1;
        strb.pairSel  = opcode[5:4];
        strb.pcStep   = 2'd3;
        nextState     = ST_WAIT;
      end
      ST_WAIT: begin
        if (waitCnt == CNT_W'(1)) nextState = ST_FETCH;
      end
      ST_HALT: nextState = ST_HALT;
      default: nextState = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_FETCH;
      opcode   <= '0;
      waitCnt  <= '0;
      illegalQ <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_OPC) opcode <= progData;
      if (state == ST_OPC && nextState == ST_HALT) illegalQ <= 1'b1;
      if (state == ST_IMM1 && opcode == OP_ADDI) waitCnt <= ADD_WAIT;
      else if (state == ST_IMM2) waitCnt <= LOAD_WAIT;
      else if (state == ST_WAIT) waitCnt <= waitCnt - CNT_W'(1);
    end
  end

  assign retire    = (state == ST_WAIT) && (waitCnt == CNT_W'(1));
  assign illegalOp = illegalQ;

endmodule

// File: rtl/tcpu_datapath.sv
module tcpu_datapath
  import tcpu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAIRS  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [7:0]        progData,
  output logic [ADDR_W-1:0] progAddr,
  output logic [7:0]        accOut,
  output logic [8*PAIRS-1:0] hiAll,
  output logic [8*PAIRS-1:0] loAll,
  output logic [15:0]       spOut,
  output logic [ADDR_W-1:0] pcOut,
  output logic [3:0]        flagsOut
);

  logic [7:0]        accQ, lowByte;
  logic [15:0]       spQ;
  logic [ADDR_W-1:0] pcQ;
  logic              zQ, nQ, hQ, cQ;

  logic [8:0] fullSum;
  logic [4:0] nibSum;

  assign fullSum = {1'b0, accQ} + {1'b0, progData};
  assign nibSum  = {1'b0, accQ[3:0]} + {1'b0, progData[3:0]};

  assign progAddr = pcQ + ADDR_W'(strb.addrOff);

  // Register pairs B:C, D:E, H:L
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic [7:0] hiQ, loQ;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hiQ <= RST_HI[p*8 +: 8];
        loQ <= RST_LO[p*8 +: 8];
      end else if (strb.loadWide && strb.pairSel == 2'(p)) begin
        hiQ <= progData;
        loQ <= lowByte;
      end
    end
    assign hiAll[p*8 +: 8] = hiQ;
    assign loAll[p*8 +: 8] = loQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accQ    <= RST_A;
      spQ     <= RST_SP;
      pcQ     <= ADDR_W'(RST_PC);
      lowByte <= '0;
      {zQ, nQ, hQ, cQ} <= RST_FLAGS;
    end else begin
      pcQ <= pcQ + ADDR_W'(strb.pcStep);
      if (strb.latchLow) lowByte <= progData;
      if (strb.loadWide && strb.pairSel == 2'd3) spQ <= {progData, lowByte};
      if (strb.doAdd) begin
        accQ <= fullSum[7:0];
        zQ   <= (fullSum[7:0] == 8'h00);
        nQ   <= 1'b0;
        hQ   <= nibSum[4];
        cQ   <= fullSum[8];
      end
    end
  end

  assign accOut   = accQ;
  assign spOut    = spQ;
  assign pcOut    = pcQ;
  assign flagsOut = {zQ, nQ, hQ, cQ};

endmodule

// File: rtl/tcpu_core.sv
module tcpu_core
  import tcpu_pkg::*;
#(
  parameter int ADD_CYCLES  = 8,
  parameter int LOAD_CYCLES = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] progAddr,
  input  logic [7:0]  progData,
  output logic        retire,
  output logic        illegalOp,
  output logic [7:0]  dbgA,
  output logic [7:0]  dbgB,
  output logic [7:0]  dbgC,
  output logic [7:0]  dbgD,
  output logic [7:0]  dbgE,
  output logic [7:0]  dbgH,
  output logic [7:0]  dbgL,
  output logic [15:0] dbgSp,
  output logic [15:0] dbgPc,
  output logic [3:0]  dbgFlags
);

  localparam int PAIRS = 3;

  strobe_t strb;
  logic [8*PAIRS-1:0] hiAll, loAll;

  tcpu_ctrl #(
    .ADD_CYCLES (ADD_CYCLES),
    .LOAD_CYCLES(LOAD_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .progData (progData),
    .strb     (strb),
    .retire   (retire),
    .illegalOp(illegalOp)
  );

  tcpu_datapath #(
    .ADDR_W(16),
    .PAIRS (PAIRS)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .progData(progData),
    .progAddr(progAddr),
    .accOut  (dbgA),
    .hiAll   (hiAll),
    .loAll   (loAll),
    .spOut   (dbgSp),
    .pcOut   (dbgPc),
    .flagsOut(dbgFlags)
  );

  assign dbgB = hiAll[7:0];
  assign dbgC = loAll[7:0];
  assign dbgD = hiAll[15:8];
  assign dbgE = loAll[15:8];
  assign dbgH = hiAll[23:16];
  assign dbgL = loAll[23:16];

endmodule

// File: rtl/tcpu_checker.sv
module tcpu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        retire,
  input logic        illegalOp,
  input logic [15:0] progAddr,
  input logic [15:0] dbgPc,
  input logic [7:0]  dbgA,
  input logic [3:0]  dbgFlags
);

  assert_sticky_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegalOp |=> illegalOp);

  assert_frozen_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegalOp |=> ($stable(dbgPc) && $stable(dbgA) && $stable(dbgFlags) && !retire));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dbgPc) |-> (dbgPc == 16'($past(dbgPc) + 16'd2) ||
                         dbgPc == 16'($past(dbgPc) + 16'd3)));

  assert_nflag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dbgFlags[2] == 1'b0);

  assert_retire_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !retire);

  assert_addr_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    16'(progAddr - dbgPc) <= 16'd2);

  assert_fetch_after_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (progAddr == dbgPc));

endmodule

bind tcpu_core tcpu_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .retire   (retire),
  .illegalOp(illegalOp),
  .progAddr (progAddr),
  .dbgPc    (dbgPc),
  .dbgA     (dbgA),
  .dbgFlags (dbgFlags)
);

// File: tb/tcpu_core_test.sv
module tcpu_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] progAddr;
  logic [7:0]  progData = 8'h00;
  logic        retire, illegalOp;
  logic [7:0]  dbgA, dbgB, dbgC, dbgD, dbgE, dbgH, dbgL;
  logic [15:0] dbgSp, dbgPc;
  logic [3:0]  dbgFlags;

  always #2.5 clk = ~clk;

  tcpu_core uut (
    .clk(clk), .rst_n(rst_n), .progAddr(progAddr), .progData(progData),
    .retire(retire), .illegalOp(illegalOp),
    .dbgA(dbgA), .dbgB(dbgB), .dbgC(dbgC), .dbgD(dbgD), .dbgE(dbgE),
    .dbgH(dbgH), .dbgL(dbgL), .dbgSp(dbgSp), .dbgPc(dbgPc), .dbgFlags(dbgFlags)
  );

  logic [7:0] rom [256];
  always @(posedge clk) progData <= rom[progAddr[7:0]];

  int total = 0;
  int bad = 0;

  // Reference model state
  logic [7:0]  mA, mB, mC, mD, mE, mH, mL;
  logic [15:0] mSp, mPc;
  logic        mZ, mN, mHf, mCf;

  task automatic check(input logic ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic isLegal(input logic [7:0] op);
    return op == 8'hC6 || op == 8'h01 || op == 8'h11 || op == 8'h21 || op == 8'h31;
  endfunction

  function automatic logic [95:0] dutState();
    return {4'h0, dbgA, dbgB, dbgC, dbgD, dbgE, dbgH, dbgL, dbgSp, dbgPc, dbgFlags};
  endfunction

  function automatic logic [95:0] modelState();
    return {4'h0, mA, mB, mC, mD, mE, mH, mL, mSp, mPc, mZ, mN, mHf, mCf};
  endfunction

  task automatic modelReset();
    mA = 8'h11; mB = 8'h00; mC = 8'h00; mD = 8'hFF; mE = 8'h56;
    mH = 8'h00; mL = 8'h0D; mSp = 16'hFFFE; mPc = 16'h0000;
    mZ = 1'b1; mN = 1'b0; mHf = 1'b0; mCf = 1'b0;
  endtask

  // Apply one instruction to the model; returns its clock cost
  task automatic modelStep(output int cost);
    logic [7:0] op, b1, b2;
    logic [8:0] s;
    op = rom[mPc[7:0]];
    b1 = rom[8'(mPc + 16'd1)];
    b2 = rom[8'(mPc + 16'd2)];
    if (op == 8'hC6) begin
      s   = {1'b0, mA} + {1'b0, b1};
      mHf = ({1'b0, mA[3:0]} + {1'b0, b1[3:0]}) > 5'd15;
      mCf = s[8];
      mA  = s[7:0];
      mZ  = (mA == 8'h00);
      mN  = 1'b0;
      mPc = mPc + 16'd2;
      cost = 8;
    end else begin
      case (op[5:4])
        2'd0: begin mB = b2; mC = b1; end
        2'd1: begin mD = b2; mE = b1; end
        2'd2: begin mH = b2; mL = b1; end
        default: mSp = {b2, b1};
      endcase
      mPc = mPc + 16'd3;
      cost = 12;
    end
  endtask

  int wp;
  task automatic putAdd(input logic [7:0] imm);
    rom[wp[7:0]] = 8'hC6; rom[8'(wp + 1)] = imm; wp += 2;
  endtask
  task automatic putLoad(input logic [7:0] op, input logic [15:0] v);
    rom[wp[7:0]] = op; rom[8'(wp + 1)] = v[7:0]; rom[8'(wp + 2)] = v[15:8]; wp += 3;
  endtask
  task automatic putBad();
    logic [7:0] b;
    b = 8'($urandom);
    while (isLegal(b)) b = 8'($urandom);
    rom[wp[7:0]] = b;
  endtask

  task automatic clearRom();
    for (int i = 0; i < 256; i++) rom[i] = 8'h00;
    wp = 0;
  endtask

  task automatic runProgram();
    int cyc, cost;
    logic fetchNext, halted;
    modelReset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dutState() == modelState(), "R1 reset values", dutState(), modelState());
    check(illegalOp == 1'b0 && retire == 1'b0, "R1 reset outputs",
          96'({illegalOp, retire}), 96'd0);
    rst_n = 1'b1;
    cyc = 1;
    fetchNext = 1'b0;
    halted = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      cyc++;
      if (fetchNext) begin
        check(progAddr == mPc, "R7 fetch address", 96'(progAddr), 96'(mPc));
        fetchNext = 1'b0;
      end
      if (illegalOp) begin
        halted = 1'b1;
        break;
      end
      if (retire) begin
        modelStep(cost);
        check(cyc == cost, "R5 instruction clocks", 96'(cyc), 96'(cost));
        check(dutState() == modelState(), "R2 R3 R4 state at retire", dutState(), modelState());
        cyc = 0;
        fetchNext = 1'b1;
      end
    end
    check(halted, "R6 watchdog: no halt seen", 96'(halted), 96'd1);
    if (halted) begin
      check(!isLegal(rom[mPc[7:0]]), "R6 halt on bad opcode", 96'(rom[mPc[7:0]]), 96'(rom[mPc[7:0]]));
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        check(illegalOp == 1'b1 && retire == 1'b0, "R6 sticky, no retire",
              96'({illegalOp, retire}), 96'b10);
      end
      check(dutState() == modelState(), "R6 frozen state", dutState(), modelState());
    end
  endtask

  initial begin
    int r;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) rom[i] = 8'h00;

    // Directed flag corners
    clearRom();
    putAdd(8'hEF);            // 0x11+0xEF = 0x00, Z H C
    putAdd(8'h00);            // 0x00, Z only
    putAdd(8'h0F);            // 0x0F, nibble sum 15: no H
    putAdd(8'h01);            // 0x10, H only
    putAdd(8'hF0);            // 0x00, Z C, no H
    putLoad(8'h31, 16'h1234);
    putLoad(8'h01, 16'hFFFF);
    putLoad(8'h11, 16'h00A5);
    putLoad(8'h21, 16'h5A00);
    putAdd(8'hFF);            // 0xFF
    putAdd(8'h01);            // 0x00 with Z H C
    rom[wp[7:0]] = 8'h76;
    runProgram();

    // Random programs
    for (int p = 0; p < 4; p++) begin
      clearRom();
      for (int n = 0; n < 40; n++) begin
        r = int'($urandom % 5);
        case (r)
          0: putAdd(8'($urandom));
          1: putLoad(8'h01, 16'($urandom));
          2: putLoad(8'h11, 16'($urandom));
          3: putLoad(8'h21, 16'($urandom));
          default: putLoad(8'h31, 16'($urandom));
        endcase
      end
      putBad();
      runProgram();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // Global watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule